// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block is a clock-slave receiver for serial audio links. It takes an external bit clock, a frame clock and a serial data line, and samples all three with the faster system clock. It detects the rising edges of the bit clock and, from the level the frame clock has at each of those edges, locates word boundaries. It then assembles parallel sample words in one of four framings, chosen by a mode input: I2S, left-justified, right-justified or DSP mode A.

Sample length, slot length and the number of slots in a DSP frame are configuration inputs. They are meant to stay constant while traffic runs. Each finished word leaves the block on a one-cycle `word_valid` strobe, together with its channel index. The serial source cannot be paused, so the output is a valid-only stream with no ready input and no back-pressure. The consumer must take every word in the cycle it is strobed. A frame-clock change that arrives before the slot has run its full length sets a sticky error flag, and the receiver restarts its framing from that change.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset `word_valid` and `frame_err` are 0. Only reset clears `frame_err`.
- R2: In I2S mode (`cfg_mode`=0), data is sampled on bit-clock rising edges. The first rising edge after a frame-clock change carries the last bit of the old slot, and the next rising edge carries the MSB of the new word. A slot with frame clock low is tagged channel 0 and a slot with it high is tagged channel 1.
- R3: In left-justified mode (`cfg_mode`=1), the bit sampled at the first rising edge with the new frame-clock level is the MSB. Frame clock high is channel 0 and low is channel 1.
- R4: In right-justified mode (`cfg_mode`=2), the word is the last `cfg_word_len` bits sampled before a frame-clock change, with the final one as LSB. It is output at that change, tagged with the slot's channel (frame clock high is 0, low is 1).
- R5: In DSP mode A (`cfg_mode`=3), a frame-clock rise starts a frame, and the next rising edge carries the MSB of slot 0. There are `cfg_dsp_slots` slots, each `cfg_slot_len` bits, sent back to back and tagged 0 upward. A frame-clock fall has no effect.
- R6: Bits of a slot past `cfg_word_len` are ignored. `word_data` holds the word right-aligned, and all bits above `cfg_word_len` are 0.
- R7: Each word produces exactly one `word_valid` pulse, one system clock wide.
- R8: A frame-clock change before `cfg_slot_len` bits of the current slot sets `frame_err`. In DSP mode this is a rise before all slots of the frame have arrived. The receiver then starts a new slot from that change and decodes the following words correctly. Back-to-back DSP frames are not errors.
- R9: In I2S mode with `cfg_word_len` equal to `cfg_slot_len`, the LSB is the bit at the rising edge where the new frame-clock level is first seen.
- R10: The first rising edge after reset only records the frame-clock level. No word is output before the first slot start. In right-justified mode, the first change produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP mode A |
| cfg_word_len | input | $clog2(WORD_MAX+1) | Sample length in bits, 1..WORD_MAX |
| cfg_slot_len | input | $clog2(SLOT_MAX+1) | Slot length in bits, at least `cfg_word_len` |
| cfg_dsp_slots | input | $clog2(CHAN_MAX+1) | Slots per DSP frame, 1..CHAN_MAX |
| bclk_in | input | 1 | External bit clock (asynchronous) |
| fsync_in | input | 1 | External frame clock (asynchronous) |
| sdata_in | input | 1 | Serial data |
| word_valid | output | 1 | One-cycle strobe for a finished word |
| word_data | output | WORD_MAX | Received word, right-aligned |
| word_chan | output | $clog2(CHAN_MAX+1) | Channel index of the word |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench builds the receiver with WORD_MAX=16, SLOT_MAX=32 and CHAN_MAX=4. These sizes allow a sample as wide as the output word inside a slot of the same length, so the I2S LSB lands on the frame-clock change itself. They also allow shorter samples in 16-bit slots, with filler ones that must be masked, and a three-slot DSP frame below the channel limit. The bit clock runs at one eighth of the system clock, which leaves room for the two-stage synchronizer.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'd0,
    FMT_LJ   = 2'd1,
    FMT_RJ   = 2'd2,
    FMT_DSPA = 2'd3
  } fmt_e;
endpackage

// File: rtl/sarx_sync.sv
// Synchronizes the three serial pins and flags rising bit-clock edges.
module sarx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic sdata_in,
  output logic bit_tick,
  output logic fs_lvl,
  output logic sd_lvl
);
  logic [2:0] raw;
  logic [2:0] pipe [STAGES];
  logic       bclk_last;

  assign raw = {sdata_in, fsync_in, bclk_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
      bclk_last <= 1'b0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      bclk_last <= pipe[STAGES-1][0];
    end
  end

  assign bit_tick = pipe[STAGES-1][0] & ~bclk_last;
  assign fs_lvl   = pipe[STAGES-1][1];
  assign sd_lvl   = pipe[STAGES-1][2];
endmodule

// File: rtl/sarx_frame_ctl.sv
// Tracks slot position and channel per bit-clock edge, decides when a word
// is complete and flags early frame-clock changes.
module sarx_frame_ctl
  import sarx_pkg::*;
#(
  parameter int WLW = 6,
  parameter int SLW = 6,
  parameter int CHW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           fs,
  input  fmt_e           fmt,
  input  logic [WLW-1:0] word_len,
  input  logic [SLW-1:0] slot_len,
  input  logic [CHW-1:0] dsp_slots,
  output logic           emit_cur,
  output logic           emit_prev,
  output logic [CHW-1:0] emit_chan,
  output logic           err_pulse
);
  logic           fs_prev, primed, active;
  logic [SLW-1:0] pos;
  logic [CHW-1:0] chan;

  logic           trans, rise, lead_start, late_start, wrap, last_slot, err;
  logic           a_act, b_act;
  logic [SLW-1:0] a_pos, b_pos, pos_inc, wl_ext;
  logic [CHW-1:0] a_chan, b_chan, chan_inc, late_chan;

  always_comb begin
    wl_ext     = SLW'(word_len);
    trans      = primed & (fs ^ fs_prev);
    rise       = primed & fs & ~fs_prev;
    // left- and right-justified slots begin on the changing edge itself
    lead_start = ((fmt == FMT_LJ) || (fmt == FMT_RJ)) & trans;
    a_act      = lead_start | active;
    a_pos      = lead_start ? '0 : pos;
    a_chan     = lead_start ? (fs ? '0 : CHW'(1)) : chan;
    // the bit on this edge belongs to slot "a"
    pos_inc    = (a_pos < slot_len) ? a_pos + SLW'(1) : a_pos;
    chan_inc   = a_chan + CHW'(1);
    wrap       = (fmt == FMT_DSPA) & a_act & (pos_inc == slot_len);
    last_slot  = (chan_inc == dsp_slots);
    b_act      = a_act & ~(wrap & last_slot);
    b_pos      = !a_act ? a_pos : (wrap ? '0 : pos_inc);
    b_chan     = wrap ? chan_inc : a_chan;
    // I2S and DSP A start the next slot one edge after the change
    late_start = ((fmt == FMT_I2S) & trans) | ((fmt == FMT_DSPA) & rise);
    late_chan  = ((fmt == FMT_I2S) && fs) ? CHW'(1) : '0;

    unique case (fmt)
      FMT_LJ, FMT_RJ: err = trans & active & (pos < slot_len);
      FMT_I2S:        err = trans & active & (b_pos < slot_len);
      default:        err = rise & b_act;
    endcase

    emit_cur  = tick & a_act & (fmt != FMT_RJ) & (a_pos == wl_ext - SLW'(1));
    emit_prev = tick & (fmt == FMT_RJ) & trans & active & ~err;
    emit_chan = emit_prev ? chan : a_chan;
    err_pulse = tick & err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev <= 1'b0;
      primed  <= 1'b0;
      active  <= 1'b0;
      pos     <= '0;
      chan    <= '0;
    end else if (tick) begin
      fs_prev <= fs;
      primed  <= 1'b1;
      if (late_start) begin
        active <= 1'b1;
        pos    <= '0;
        chan   <= late_chan;
      end else begin
        active <= b_act;
        pos    <= b_pos;
        chan   <= b_chan;
      end
    end
  end
endmodule

// File: rtl/sarx_word_path.sv
// Serial-to-parallel shift register and the single output register.
module sarx_word_path #(
  parameter int WORD_MAX = 32,
  parameter int WLW      = 6,
  parameter int CHW      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                sd,
  input  logic                emit_cur,
  input  logic                emit_prev,
  input  logic [CHW-1:0]      emit_chan,
  input  logic [WLW-1:0]      word_len,
  output logic                word_valid,
  output logic [WORD_MAX-1:0] word_data,
  output logic [CHW-1:0]      word_chan
);
  logic [WORD_MAX-1:0] sh, sh_next, mask;

  always_comb begin
    sh_next = {sh[WORD_MAX-2:0], sd};
    for (int i = 0; i < WORD_MAX; i++) mask[i] = (WLW'(i) < word_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh         <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_chan  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (tick) begin
        sh <= sh_next;
        if (emit_cur || emit_prev) begin
          word_valid <= 1'b1;
          word_data  <= (emit_cur ? sh_next : sh) & mask;
          word_chan  <= emit_chan;
        end
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter  int WORD_MAX    = 32,
  parameter  int SLOT_MAX    = 32,
  parameter  int CHAN_MAX    = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int WLW         = $clog2(WORD_MAX + 1),
  localparam int SLW         = $clog2(SLOT_MAX + 1),
  localparam int CHW         = $clog2(CHAN_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_mode,
  input  logic [WLW-1:0]      cfg_word_len,
  input  logic [SLW-1:0]      cfg_slot_len,
  input  logic [CHW-1:0]      cfg_dsp_slots,
  input  logic                bclk_in,
  input  logic                fsync_in,
  input  logic                sdata_in,
  output logic                word_valid,
  output logic [WORD_MAX-1:0] word_data,
  output logic [CHW-1:0]      word_chan,
  output logic                frame_err
);
  logic           tick, fs_s, sd_s;
  logic           emit_cur, emit_prev, err_pulse;
  logic [CHW-1:0] emit_chan;
  logic           err_q;

  sarx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .sdata_in(sdata_in),
    .bit_tick(tick), .fs_lvl(fs_s), .sd_lvl(sd_s)
  );

  sarx_frame_ctl #(.WLW(WLW), .SLW(SLW), .CHW(CHW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fs(fs_s),
    .fmt(fmt_e'(cfg_mode)), .word_len(cfg_word_len),
    .slot_len(cfg_slot_len), .dsp_slots(cfg_dsp_slots),
    .emit_cur(emit_cur), .emit_prev(emit_prev),
    .emit_chan(emit_chan), .err_pulse(err_pulse)
  );

  sarx_word_path #(.WORD_MAX(WORD_MAX), .WLW(WLW), .CHW(CHW)) u_path (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sd(sd_s),
    .emit_cur(emit_cur), .emit_prev(emit_prev), .emit_chan(emit_chan),
    .word_len(cfg_word_len),
    .word_valid(word_valid), .word_data(word_data), .word_chan(word_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (err_pulse) err_q <= 1'b1;
  end

  assign frame_err = err_q;
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter  int WORD_MAX = 32,
  parameter  int SLOT_MAX = 32,
  parameter  int CHAN_MAX = 8,
  localparam int WLW      = $clog2(WORD_MAX + 1),
  localparam int CHW      = $clog2(CHAN_MAX + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          cfg_mode,
  input logic [WLW-1:0]      cfg_word_len,
  input logic [CHW-1:0]      cfg_dsp_slots,
  input logic                word_valid,
  input logic [WORD_MAX-1:0] word_data,
  input logic [CHW-1:0]      word_chan,
  input logic                frame_err
);
  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!word_valid && !frame_err));

  // R7
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  // R8
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  // R6
  assert_upper_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> ((word_data >> cfg_word_len) == '0));

  // R5
  assert_dsp_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cfg_mode == 2'd3) |-> (word_chan < cfg_dsp_slots));

  // R2
  assert_pair_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && cfg_mode != 2'd3) |-> (word_chan <= CHW'(1)));
endmodule

bind serial_audio_rx sarx_chk #(
  .WORD_MAX(WORD_MAX), .SLOT_MAX(SLOT_MAX), .CHAN_MAX(CHAN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
  .cfg_word_len(cfg_word_len), .cfg_dsp_slots(cfg_dsp_slots),
  .word_valid(word_valid), .word_data(word_data),
  .word_chan(word_chan), .frame_err(frame_err)
);

// File: tb/sim_serial_audio_rx.sv
module sim_serial_audio_rx;
  localparam int WM = 16, SM = 32, CM = 4;
  localparam int WLW = $clog2(WM + 1), SLW = $clog2(SM + 1), CHW = $clog2(CM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [WLW-1:0] wl = '0;
  logic [SLW-1:0] sl = '0;
  logic [CHW-1:0] ns = '0;
  logic bclk = 1'b0, fs = 1'b0, sd = 1'b0;
  logic word_valid, frame_err;
  logic [WM-1:0] word_data;
  logic [CHW-1:0] word_chan;

  int n_chk = 0, n_bad = 0, pulse_bad = 0;
  bit vprev = 1'b0;
  bit ef[$], ed[$], dd[$];
  int xd[$], xc[$], gd[$], gc[$];

  always #10 clk = ~clk;

  serial_audio_rx #(.WORD_MAX(WM), .SLOT_MAX(SM), .CHAN_MAX(CM)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(mode), .cfg_word_len(wl),
    .cfg_slot_len(sl), .cfg_dsp_slots(ns), .bclk_in(bclk),
    .fsync_in(fs), .sdata_in(sd), .word_valid(word_valid),
    .word_data(word_data), .word_chan(word_chan), .frame_err(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (word_valid) begin
        gd.push_back(int'(word_data));
        gc.push_back(int'(word_chan));
        if (vprev) pulse_bad++;
      end
      vprev = word_valid;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bclk = 1'b0; fs = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    gd.delete(); gc.delete(); xd.delete(); xc.delete();
    ef.delete(); ed.delete(); dd.delete();
  endtask

  task automatic edge_add(input bit f, input bit d);
    ef.push_back(f); ed.push_back(d);
  endtask

  task automatic play();
    foreach (ef[i]) begin
      @(negedge clk);
      bclk = 1'b0; fs = ef[i]; sd = ed[i];
      repeat (3) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    @(negedge clk) bclk = 1'b0;
    repeat (12) @(negedge clk);
    ef.delete(); ed.delete();
  endtask

  // one slot of serial bits, MSB first, filler ones in unused positions
  task automatic slot_add(input int v, input int w, input int s, input bit rj, input int ch);
    for (int j = 0; j < s; j++) begin
      if (rj) dd.push_back((j < s - w) ? 1'b1 : 1'(v >> (w - 1 - (j - (s - w)))));
      else    dd.push_back((j < w) ? 1'(v >> (w - 1 - j)) : 1'b1);
    end
    xd.push_back(v & ((1 << w) - 1));
    xc.push_back(ch);
  endtask

  task automatic build_i2s(input int s, input bit first_lvl, input bit d0);
    for (int n = 0; n <= dd.size(); n++)
      edge_add(first_lvl ^ 1'((n / s) % 2), (n == 0) ? d0 : dd[n-1]);
  endtask

  task automatic build_lj(input int s);
    for (int n = 0; n <= dd.size(); n++)
      edge_add(1'b1 ^ 1'((n / s) % 2), (n < dd.size()) ? dd[n] : 1'b0);
  endtask

  task automatic build_dsp(input int fl, input int hi);
    for (int n = 0; n <= dd.size(); n++)
      edge_add((n % fl) < hi, (n == 0) ? 1'b0 : dd[n-1]);
  endtask

  task automatic compare(input string req);
    chk(gd.size() == xd.size(), {req, " word count"}, gd.size(), xd.size());
    foreach (xd[i]) begin
      if (i < gd.size()) begin
        chk(gd[i] == xd[i], {req, " data"}, gd[i], xd[i]);
        chk(gc[i] == xc[i], {req, " chan"}, gc[i], xc[i]);
      end
    end
  endtask

  task automatic t_reset();
    mode = 2'd0; wl = 5'd8; sl = 6'd16; ns = 3'd2;
    do_reset();
    chk(word_valid == 1'b0, "R1 valid", word_valid, 0);
    chk(frame_err == 1'b0, "R1 err", frame_err, 0);
  endtask

  task automatic t_i2s_narrow();  // R2, R6
    mode = 2'd0; wl = 5'd8; sl = 6'd16; do_reset();
    repeat (3) edge_add(1'b1, 1'b0);
    slot_add('hA5, 8, 16, 0, 0); slot_add('h3C, 8, 16, 0, 1);
    slot_add('h81, 8, 16, 0, 0); slot_add('h7E, 8, 16, 0, 1);
    build_i2s(16, 1'b0, 1'b0); play();
    compare("R2/R6");
  endtask

  task automatic t_i2s_full();  // R9
    mode = 2'd0; wl = 5'd16; sl = 6'd16; do_reset();
    repeat (3) edge_add(1'b1, 1'b0);
    slot_add('hBEEF, 16, 16, 0, 0); slot_add('h1234, 16, 16, 0, 1);
    slot_add('h8001, 16, 16, 0, 0); slot_add('h7FFE, 16, 16, 0, 1);
    build_i2s(16, 1'b0, 1'b0); play();
    compare("R9");
  endtask

  task automatic t_lj();  // R3
    mode = 2'd1; wl = 5'd12; sl = 6'd16; do_reset();
    repeat (3) edge_add(1'b0, 1'b0);
    slot_add('hABC, 12, 16, 0, 0); slot_add('h123, 12, 16, 0, 1);
    slot_add('hF0F, 12, 16, 0, 0); slot_add('h801, 12, 16, 0, 1);
    build_lj(16); play();
    compare("R3");
  endtask

  task automatic t_rj();  // R4, R10
    mode = 2'd2; wl = 5'd12; sl = 6'd16; do_reset();
    repeat (3) edge_add(1'b0, 1'b0);
    slot_add('h9A5, 12, 16, 1, 0); slot_add('h00F, 12, 16, 1, 1);
    slot_add('hC01, 12, 16, 1, 0); slot_add('h7E7, 12, 16, 1, 1);
    build_lj(16); play();
    compare("R4/R10");
  endtask

  task automatic t_dsp();  // R5
    mode = 2'd3; wl = 5'd8; sl = 6'd10; ns = 3'd3; do_reset();
    repeat (3) edge_add(1'b0, 1'b0);
    for (int i = 0; i < 6; i++) slot_add(('h17 * (i + 3)) & 'hFF, 8, 10, 0, i % 3);
    build_dsp(30, 2); play();
    compare("R5");
    chk(frame_err == 1'b0, "R8 back-to-back frames", frame_err, 0);
  endtask

  task automatic t_err();  // R8, R1
    mode = 2'd0; wl = 5'd8; sl = 6'd16; do_reset();
    repeat (3) edge_add(1'b1, 1'b0);
    slot_add('h5A, 8, 16, 0, 0); slot_add('hC3, 8, 16, 0, 1);
    build_i2s(16, 1'b0, 1'b0); play();
    chk(frame_err == 1'b0, "R8 clean before", frame_err, 0);
    repeat (5) edge_add(1'b0, 1'b1);
    dd.delete();
    slot_add('h66, 8, 16, 0, 1); slot_add('h99, 8, 16, 0, 0);
    build_i2s(16, 1'b1, 1'b1); play();
    chk(frame_err == 1'b1, "R8 short slot", frame_err, 1);
    compare("R8 resync");
    do_reset();
    chk(frame_err == 1'b0, "R1 reset clears err", frame_err, 0);
  endtask

  initial begin
    t_reset();
    t_i2s_narrow();
    t_i2s_full();
    t_lj();
    t_rj();
    t_dsp();
    t_err();
    chk(pulse_bad == 0, "R7 pulse width", pulse_bad, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule